// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a bitstream into a target FPGA over a slave-serial style link. On a start request it holds the target's active-low program line low and watches the target's open-drain init line fall. It then releases the program line and waits for init to return high. It confirms that the done line is still low and waits a fixed program latency. After that it takes configuration bytes from a valid/ready byte stream and shifts them out on a serial data pin beside a generated configuration clock. Once the byte marked last has gone out, it keeps clocking 0xFF padding bytes while it polls done. It then reports a one-cycle finish pulse with a result code.

Every interval is a parameter counted in system clock cycles: the minimum program pulse, the init timeout, the fallback delay used when no init line is wired, the program latency, the completion timeout and the half-period of the configuration clock. The init and done pins pass through two-flop synchronizers. Byte stream rules: a byte moves on a rising system clock edge where both `s_valid_i` and `s_ready_o` are high. The source may hold valid low for any number of cycles. `s_ready_o` rises only in the data phase, when the serializer is empty and the last byte has not yet been taken, so the source is stalled for the whole 8-bit shift of each byte.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, `prog_n_o` is 1, `cclk_o` is 0, and `s_ready_o`, `busy_o` and `fin_o` are 0. A start request with `partial_i` low drives `prog_n_o` low for at least PROG_CYC cycles, and with an init line present it stays low until init is seen low.
- R2: A start request with `partial_i` high gives a `fin_o` pulse with code 1 (refused request). `prog_n_o` never goes low and no configuration clock is produced.
- R3: If init is not seen low within INIT_TMO_CYC cycles of the program line falling, the result is code 2 (init timeout) and the program line is released no later than the finish pulse. The same code results if init is not seen high within INIT_TMO_CYC cycles of release.
- R4: With `init_present_i` low, the level of `init_n_i` has no effect. Each init wait becomes a fixed ALT_CYC delay, which also stretches the program pulse, and no init timeout can occur.
- R5: If done reads high once the init wait after release has ended, the result is code 3 (early done) and no configuration clock edge is produced.
- R6: At least LAT_CYC cycles pass between init returning high and the first rising edge of `cclk_o`.
- R7: Bytes are shifted MSB first. `dout_o` changes only while `cclk_o` is low, so it is stable across every high phase. Each level of `cclk_o` lasts CLK_HALF system cycles.
- R8: `s_ready_o` is high only in the data phase, and only while the program line is released and the serializer is idle. Every byte accepted appears on `dout_o` in order, and no byte is taken after the one marked by `s_last_i`.
- R9: After the last byte, one 0xFF byte is clocked out on every done poll, including the poll that finds done high. That poll ends the run with code 0. If done rises during pad byte N, exactly N+1 pad bytes are sent.
- R10: Once CLK_TMO... once DONE_TMO_CYC cycles have passed in the padding phase, one final poll is made. If done is still low, the code is 4 (CRC or device error) when the init pin reads low, 5 (missing sync word or incomplete data) when it reads high, and 6 (plain timeout) when no init line is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| partial_i | input | 1 | Request is for partial reconfiguration (refused) |
| init_present_i | input | 1 | High when the init line is wired and observable |
| init_n_i | input | 1 | Target init pin, low = asserted |
| done_i | input | 1 | Target done pin |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | 8 | Byte stream data |
| s_last_i | input | 1 | Marks the final configuration byte |
| s_ready_o | output | 1 | Byte stream ready |
| prog_n_o | output | 1 | Target program line, active low |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A run is in progress |
| fin_o | output | 1 | One-cycle pulse when a run ends |
| code_o | output | 3 | Result of the latest run, held until the next |

## Verification
The hardest situation to reach is the done poll that must still send a pad byte after done is first seen. Done has to change inside a particular pad byte, and it passes through a synchronizer first. The bench's target model counts configuration clock rises and raises done right after the last rising edge of pad N, so the exact pad count can be predicted. The two timeout diagnoses are reached by letting the completion timer run out. In one of these runs the bench pulls the init pin low after data has started, and in the other it leaves the pin high. The init timeouts come from a target model that either never answers the program pulse or never releases init.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_RELEASE,
    ST_LATENCY,
    ST_STREAM,
    ST_PAD
  } seq_state_e;

  typedef enum logic [2:0] {
    RC_OK         = 3'd0,
    RC_BAD_REQ    = 3'd1,
    RC_INIT_TMO   = 3'd2,
    RC_EARLY_DONE = 3'd3,
    RC_CRC        = 3'd4,
    RC_SYNC       = 3'd5,
    RC_CFG_TMO    = 3'd6
  } result_e;

  function automatic int larger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end

endmodule

// File: rtl/cfgseq_shifter.sv
module cfgseq_shifter #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       busy_o,
  output logic       cclk_o,
  output logic       dout_o
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic          cclk_q, dout_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      cclk_q <= 1'b0;
      dout_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      sh_q   <= byte_i;
      dout_q <= byte_i[7];
      cclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_END) begin
        cnt_q <= '0;
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          cclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
          end else begin
            bit_q  <= bit_q + 3'd1;
            sh_q   <= {sh_q[6:0], 1'b0};
            dout_q <= sh_q[6];
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign cclk_o = cclk_q;
  assign dout_o = dout_q;

  // R8
  load_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);

  // R7
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_q ##1 cclk_q) |-> $stable(dout_q));

endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl import cfgseq_pkg::*; #(
  parameter int PROG_CYC     = 100,
  parameter int INIT_TMO_CYC = 200_000_000,
  parameter int ALT_CYC      = 200,
  parameter int LAT_CYC      = 1_500_000,
  parameter int DONE_TMO_CYC = 20_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic       init_present_i,
  input  logic       init_lo_i,
  input  logic       done_i,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       sh_busy_i,
  output logic       ld_o,
  output logic [7:0] ld_byte_o,
  output logic       prog_n_o,
  output logic       busy_o,
  output logic       fin_o,
  output logic [2:0] code_o
);

  localparam int TMAX = larger(larger(larger(PROG_CYC, INIT_TMO_CYC), larger(ALT_CYC, LAT_CYC)),
                               DONE_TMO_CYC);
  localparam int TW = $clog2(TMAX + 1) + 1;
  localparam logic [TW-1:0] LIM_PROG = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] LIM_ITMO = TW'(INIT_TMO_CYC - 1);
  localparam logic [TW-1:0] LIM_ALT  = TW'(ALT_CYC - 1);
  localparam logic [TW-1:0] LIM_LAT  = TW'(LAT_CYC - 1);
  localparam logic [TW-1:0] LIM_DONE = TW'(DONE_TMO_CYC - 1);
  localparam logic [TW-1:0] TSAT     = '1;

  seq_state_e st_q, st_nx;
  result_e    code_q, code_nx;
  logic [TW-1:0] tmr_q;
  logic fin_q, fin_nx;
  logic last_q, poll_q, poll_done_q, poll_exp_q, pad_issue;
  logic pulse_ok, alt_ok, itmo_ok, lat_ok, exp_ok, wait_lo_ok, wait_hi_ok;

  assign pulse_ok   = tmr_q >= LIM_PROG;
  assign alt_ok     = tmr_q >= LIM_ALT;
  assign itmo_ok    = init_present_i && (tmr_q >= LIM_ITMO);
  assign lat_ok     = tmr_q >= LIM_LAT;
  assign exp_ok     = tmr_q >= LIM_DONE;
  assign wait_lo_ok = init_present_i ? init_lo_i : alt_ok;
  assign wait_hi_ok = init_present_i ? !init_lo_i : alt_ok;

  assign s_ready_o = (st_q == ST_STREAM) && !sh_busy_i && !last_q;

  always_comb begin
    st_nx     = st_q;
    fin_nx    = 1'b0;
    code_nx   = code_q;
    ld_o      = 1'b0;
    ld_byte_o = s_data_i;
    pad_issue = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (partial_i) begin
            fin_nx  = 1'b1;
            code_nx = RC_BAD_REQ;
          end else begin
            st_nx = ST_ASSERT;
          end
        end
      end
      ST_ASSERT: begin
        if (pulse_ok && wait_lo_ok) begin
          st_nx = ST_RELEASE;
        end else if (itmo_ok) begin
          st_nx   = ST_IDLE;
          fin_nx  = 1'b1;
          code_nx = RC_INIT_TMO;
        end
      end
      ST_RELEASE: begin
        if (wait_hi_ok) begin
          if (done_i) begin
            st_nx   = ST_IDLE;
            fin_nx  = 1'b1;
            code_nx = RC_EARLY_DONE;
          end else begin
            st_nx = ST_LATENCY;
          end
        end else if (itmo_ok) begin
          st_nx   = ST_IDLE;
          fin_nx  = 1'b1;
          code_nx = RC_INIT_TMO;
        end
      end
      ST_LATENCY: begin
        if (lat_ok) st_nx = ST_STREAM;
      end
      ST_STREAM: begin
        ld_o = s_ready_o && s_valid_i;
        if (last_q && !sh_busy_i) st_nx = ST_PAD;
      end
      ST_PAD: begin
        if (!sh_busy_i) begin
          if (poll_q && (poll_done_q || poll_exp_q)) begin
            st_nx  = ST_IDLE;
            fin_nx = 1'b1;
            if (poll_done_q)          code_nx = RC_OK;
            else if (!init_present_i) code_nx = RC_CFG_TMO;
            else if (init_lo_i)       code_nx = RC_CRC;
            else                      code_nx = RC_SYNC;
          end else begin
            ld_o      = 1'b1;
            ld_byte_o = 8'hFF;
            pad_issue = 1'b1;
          end
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      code_q      <= RC_OK;
      fin_q       <= 1'b0;
      tmr_q       <= '0;
      last_q      <= 1'b0;
      poll_q      <= 1'b0;
      poll_done_q <= 1'b0;
      poll_exp_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      code_q <= code_nx;
      fin_q  <= fin_nx;
      if (st_nx != st_q)     tmr_q <= '0;
      else if (tmr_q != TSAT) tmr_q <= tmr_q + 1'b1;
      if (st_q == ST_IDLE)                 last_q <= 1'b0;
      else if (ld_o && st_q == ST_STREAM) last_q <= s_last_i;
      if (st_q != ST_PAD) begin
        poll_q <= 1'b0;
      end else if (pad_issue) begin
        poll_q      <= 1'b1;
        poll_done_q <= done_i;
        poll_exp_q  <= exp_ok;
      end
    end
  end

  assign prog_n_o = (st_q != ST_ASSERT);
  assign busy_o   = (st_q != ST_IDLE);
  assign fin_o    = fin_q;
  assign code_o   = code_q;

  // R3
  fin_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> prog_n_o);

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (prog_n_o && !sh_busy_i && busy_o));

  // R2
  bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && partial_i) |=> (fin_o && code_o == 3'd1 && prog_n_o));

  // R1
  prog_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n_o) |-> $past(start_i && !partial_i));

  // R9
  pad_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAD && ld_o) |-> (ld_byte_o == 8'hFF));

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq import cfgseq_pkg::*; #(
  parameter int CLK_HALF     = 5,
  parameter int PROG_CYC     = 100,
  parameter int INIT_TMO_CYC = 200_000_000,
  parameter int ALT_CYC      = 200,
  parameter int LAT_CYC      = 1_500_000,
  parameter int DONE_TMO_CYC = 20_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic       init_present_i,
  input  logic       init_n_i,
  input  logic       done_i,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       dout_o,
  output logic       busy_o,
  output logic       fin_o,
  output logic [2:0] code_o
);

  logic [1:0] pins_s;
  logic       sh_busy, ld;
  logic [7:0] ld_byte;

  cfgseq_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({done_i, init_n_i}),
    .q_o   (pins_s)
  );

  cfgseq_ctrl #(
    .PROG_CYC     (PROG_CYC),
    .INIT_TMO_CYC (INIT_TMO_CYC),
    .ALT_CYC      (ALT_CYC),
    .LAT_CYC      (LAT_CYC),
    .DONE_TMO_CYC (DONE_TMO_CYC)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .partial_i      (partial_i),
    .init_present_i (init_present_i),
    .init_lo_i      (!pins_s[0]),
    .done_i         (pins_s[1]),
    .s_valid_i      (s_valid_i),
    .s_data_i       (s_data_i),
    .s_last_i       (s_last_i),
    .s_ready_o      (s_ready_o),
    .sh_busy_i      (sh_busy),
    .ld_o           (ld),
    .ld_byte_o      (ld_byte),
    .prog_n_o       (prog_n_o),
    .busy_o         (busy_o),
    .fin_o          (fin_o),
    .code_o         (code_o)
  );

  cfgseq_shifter #(.HALF(CLK_HALF)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ld),
    .byte_i (ld_byte),
    .busy_o (sh_busy),
    .cclk_o (cclk_o),
    .dout_o (dout_o)
  );

endmodule

// File: tb/tb_fpga_cfg_seq.sv
`timescale 1ns/1ps
module tb_fpga_cfg_seq;
  localparam int HALF = 4, PROG = 20, ITMO = 400, ALT = 50, LAT = 60, DTMO = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, partial_i = 1'b0, init_present_i = 1'b1;
  logic done_pin = 1'b0, s_valid_i = 1'b0, s_last_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_ready_o, prog_n_o, cclk_o, dout_o, busy_o, fin_o;
  logic [2:0] code_o;
  logic tgt_init_n = 1'b1, force_lo = 1'b0;
  wire  init_pin = tgt_init_n & ~force_lo;

  always #2.5 clk = ~clk;

  fpga_cfg_seq #(.CLK_HALF(HALF), .PROG_CYC(PROG), .INIT_TMO_CYC(ITMO), .ALT_CYC(ALT),
                 .LAT_CYC(LAT), .DONE_TMO_CYC(DTMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
    .init_present_i(init_present_i), .init_n_i(init_pin), .done_i(done_pin),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .dout_o(dout_o), .busy_o(busy_o),
    .fin_o(fin_o), .code_o(code_o));

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference state for one run
  logic [7:0] mem [16];
  bit   bitq [$];
  int   feed_n = 0, idx = 0, gap = 0, nb_v = 0, dn_after_v = -1;
  bit   took = 0, stall = 0, done_force = 0, crc_mode = 0;
  bit   tgt_resp = 1, tgt_hold = 0;
  int   rises = 0, first_rise = -1, rel_cyc = -1, prog_falls = 0, lo_run = 0, last_pulse = 0;
  int   fin_cnt = 0, last_code = 0, acnt = 0, rcnt = 0;
  logic cclk_prev = 1'b0, dout_prev = 1'b0, prog_prev = 1'b1;

  // byte source with optional gaps after each transfer
  always @(negedge clk) begin
    if (took) begin
      for (int b = 7; b >= 0; b--) bitq.push_back(mem[idx][b]);
      idx++;
      gap = stall ? 7 : 0;
    end
    if (gap > 0) begin
      gap--;
      s_valid_i = 1'b0;
    end else begin
      s_valid_i = (idx < feed_n);
    end
    s_data_i = mem[idx % 16];
    s_last_i = (idx == feed_n - 1);
    took = s_valid_i && s_ready_o;
  end

  // target device model and cycle-by-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (!prog_n_o) begin
      rcnt = 0;
      if (tgt_resp) begin
        if (acnt == 5) tgt_init_n = 1'b0; else acnt++;
      end
    end else begin
      acnt = 0;
      if (!tgt_init_n && !tgt_hold) begin
        if (rcnt == 8) begin tgt_init_n = 1'b1; rel_cyc = cyc; end
        else rcnt++;
      end
    end
    if (!prog_n_o) lo_run++;
    if (prog_prev && !prog_n_o) prog_falls++;
    if (!prog_prev && prog_n_o) begin last_pulse = lo_run; lo_run = 0; end
    if (cclk_o && !cclk_prev) begin
      bit expb;
      rises++;
      if (first_rise < 0) first_rise = cyc;
      expb = (bitq.size() > 0) ? bitq.pop_front() : 1'b1;
      chk(dout_o == expb, "R7", "serial bit", int'(dout_o), int'(expb));
    end
    if (cclk_o && cclk_prev)
      chk(dout_o == dout_prev, "R7", "data held in high phase", int'(dout_o), int'(dout_prev));
    if (s_ready_o)
      chk(prog_n_o && busy_o, "R8", "ready outside data phase", int'(prog_n_o), 1);
    if (fin_o) begin fin_cnt++; last_code = int'(code_o); end
    if (crc_mode && rises > 0) force_lo = 1'b1;
    done_pin = done_force || (dn_after_v >= 0 && rises >= 8 * (nb_v + dn_after_v));
    cclk_prev = cclk_o; dout_prev = dout_o; prog_prev = prog_n_o;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_run(input int nb, input bit part, input int dn_after, input int seed);
    int w;
    rises = 0; first_rise = -1; rel_cyc = -1; prog_falls = 0; fin_cnt = 0; last_pulse = 0;
    bitq.delete(); idx = 0; gap = 0; took = 0;
    nb_v = nb; dn_after_v = dn_after;
    for (int i = 0; i < 16; i++) mem[i] = 8'((seed * 53 + i * 91) ^ (i << 3) ^ 8'hA5);
    @(negedge clk);
    feed_n = part ? 0 : nb;
    start_i = 1'b1; partial_i = part;
    @(negedge clk);
    start_i = 1'b0; partial_i = 1'b0;
    w = 0;
    while (fin_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
    chk(fin_cnt == 1, "R1", "run finished", fin_cnt, 1);
    feed_n = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_n_o == 1'b1, "R1", "reset prog_n", int'(prog_n_o), 1);
    chk(cclk_o == 1'b0 && s_ready_o == 1'b0, "R1", "reset cclk/ready", int'(cclk_o) + int'(s_ready_o), 0);
    chk(busy_o == 1'b0 && fin_o == 1'b0, "R1", "reset busy/fin", int'(busy_o) + int'(fin_o), 0);

    // normal run, done after pad 2
    do_run(4, 0, 2, 1);
    chk(last_code == 0, "R9", "success code", last_code, 0);
    chk(rises == 8 * 7, "R9", "data plus 3 pads", rises, 56);
    chk(last_pulse >= PROG, "R1", "program pulse width", last_pulse, PROG);
    chk(first_rise - rel_cyc >= LAT, "R6", "program latency", first_rise - rel_cyc, LAT);
    chk(bitq.size() == 0, "R8", "all accepted bits sent", bitq.size(), 0);

    // single byte, done already seen on the first poll, pad still sent
    do_run(1, 0, 0, 2);
    chk(last_code == 0, "R9", "success on first poll", last_code, 0);
    chk(rises == 16, "R9", "one pad on done poll", rises, 16);

    // back-pressured source
    stall = 1;
    do_run(6, 0, 1, 3);
    stall = 0;
    chk(last_code == 0, "R8", "gapped stream success", last_code, 0);
    chk(rises == 8 * 8, "R8", "gapped stream bit count", rises, 64);

    // partial reconfiguration refused
    do_run(3, 1, 0, 4);
    chk(last_code == 1, "R2", "refused code", last_code, 1);
    chk(prog_falls == 0 && rises == 0, "R2", "pins untouched", prog_falls + rises, 0);

    // init never asserts
    tgt_resp = 0;
    do_run(2, 0, 0, 5);
    chk(last_code == 2, "R3", "init assert timeout", last_code, 2);
    chk(prog_n_o == 1'b1, "R3", "program released", int'(prog_n_o), 1);
    chk(last_pulse == ITMO, "R3", "pulse equals timeout", last_pulse, ITMO);
    tgt_resp = 1;

    // init never released
    tgt_hold = 1;
    do_run(2, 0, 0, 6);
    chk(last_code == 2, "R3", "init release timeout", last_code, 2);
    chk(rises == 0, "R3", "no clock after timeout", rises, 0);
    tgt_hold = 0;
    repeat (20) @(negedge clk);

    // done high before data
    done_force = 1;
    do_run(2, 0, -1, 7);
    done_force = 0;
    chk(last_code == 3, "R5", "early done code", last_code, 3);
    chk(rises == 0, "R5", "no clock on early done", rises, 0);

    // completion timeout with init high
    do_run(3, 0, -1, 8);
    chk(last_code == 5, "R10", "sync/incomplete code", last_code, 5);
    chk(rises % 8 == 0 && rises >= 8 * 4, "R10", "whole pad bytes", rises, 32);

    // completion timeout with init pulled low during data
    crc_mode = 1;
    do_run(3, 0, -1, 9);
    crc_mode = 0; force_lo = 1'b0;
    chk(last_code == 4, "R10", "CRC code", last_code, 4);

    // no init line: pin held high by an unresponsive target is ignored
    init_present_i = 1'b0; tgt_resp = 0;
    do_run(2, 0, 1, 10);
    chk(last_code == 0, "R4", "success without init line", last_code, 0);
    chk(last_pulse == ALT, "R4", "fallback delay pulse", last_pulse, ALT);
    chk(rises == 8 * 4, "R4", "bit count without init line", rises, 32);

    do_run(2, 0, -1, 11);
    chk(last_code == 6, "R10", "plain timeout code", last_code, 6);
    init_present_i = 1'b1; tgt_resp = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule